// File: doc/BRIEF.md
# Quad DAC Serial Command Decoder

This block is the digital front end of a four-channel digital-to-analog converter. A host talks to it over a mode-0 SPI link (clock idle low, data sampled on the rising clock edge, most significant bit first). The host sends 24-bit command words while chip select is held low. Each word carries a 4-bit operation code, a 4-bit channel mask and a 16-bit data field. For every channel the block keeps a staging register and a live register. It also holds a 2-bit power state per channel and an internal-reference enable. It drives the four live codes, the power states and the reference enable straight to the analog side.

The SPI pins are brought into the system clock domain through a synchronizer of configurable depth. Edges are detected on the synchronized copies. A word is acted on only when chip select rises after exactly 24 serial clock edges. A readback request is held until the next frame. During that frame the selected staging register is shifted out on MISO, so the staging contents can be seen at the pins. The converter resolution is a parameter of 12, 14 or 16 bits. The code sits left-aligned in the data field, and any bits below the resolution are dropped.

Top module: `qdac_cmd_decoder`

## Requirements
- R1: A word is laid out as operation in bits 23:20, channel mask in bits 19:16 and data in bits 15:0, sent most significant bit first. It is acted on only if chip select rises after exactly 24 rising serial clock edges. Frames of 23 or 25 edges change nothing.
- R2: After hardware reset, all live codes are 0, all power states are 00, the reference enable is 1 and MISO is 0.
- R3: Operation 0x1 loads the data into the staging register of every channel n whose mask bit n is 1 (mask 0xF selects all four channels). The live codes do not change.
- R4: Operation 0x2 copies the staging register into the live register for every selected channel.
- R5: Operation 0x3 loads the data into both the staging and live registers of every selected channel.
- R6: Operation 0x4 sets the power state of channel n from data bits 2n+1:2n and ignores the mask. The codes are 00 normal, 01 1 kOhm to ground, 10 100 kOhm to ground and 11 three-state.
- R7: Operation 0x7 drives the reference enable to the inverse of data bit 0.
- R8: Operation 0x9 arms a readback. During the next frame MISO carries 24 bits, MSB first. Bits 23:16 are zero. Bits 15:0 are the left-aligned staging register of the lowest-numbered selected channel, or zero if the mask is 0. In a frame with no armed readback MISO stays 0. MISO changes after falling serial clock edges, and its first bit is valid before the first rising edge.
- R9: Operation 0x6 clears all staging registers, live codes and power states, and drops an armed readback. The reference enable is left unchanged.
- R10: Operations 0x0, 0x5, 0x8 and 0xA to 0xF change no output and no staging register.
- R11: Only data bits 15 down to 16-DAC_BITS are kept. Lower data bits have no effect on any code or readback.
- R12: Outputs change on the (SYNC_STAGES+2)-th rising system clock edge after chip select rises at the pin, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial readback data to the host |
| dac_codes | output | NUM_CH*DAC_BITS | Live codes, channel n at bits n*DAC_BITS upward |
| pd_modes | output | 2*NUM_CH | Power state, channel n at bits 2n+1:2n |
| int_ref_en | output | 1 | Internal reference enable |

## Verification
Every frame's register effects appear four clock edges after the bench raises chip select, with the default two-stage synchronizer. The scoreboard therefore stamps each expected item with the cycle count at the release of chip select plus that latency. It checks the old state one cycle before that point and the new state on that cycle, which pins the latency exactly. Readback bits are sampled by the bench just before each rising serial clock edge. Each edge is eight system clocks after the previous fall, which leaves room for the synchronizer and shifter delay. The captured word is then compared in frame order with the value the model predicts when chip select falls.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
   localparam int FRAME_W = 24;
   localparam int OP_W    = 4;
   localparam int MASK_W  = 4;
   localparam int DATA_W  = 16;
   localparam int NUM_CH  = 4;

   typedef enum logic [OP_W-1:0] {
      OP_NOP     = 4'h0,
      OP_STAGE   = 4'h1,
      OP_PROMOTE = 4'h2,
      OP_DIRECT  = 4'h3,
      OP_POWER   = 4'h4,
      OP_GATE    = 4'h5,
      OP_CLEAR   = 4'h6,
      OP_REFSEL  = 4'h7,
      OP_CHAIN   = 4'h8,
      OP_PEEK    = 4'h9
   } op_e;

   typedef struct packed {
      logic [OP_W-1:0]   op;
      logic [MASK_W-1:0] mask;
      logic [DATA_W-1:0] data;
   } frame_t;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
   parameter int            STAGES  = 2,
   parameter int            W       = 3,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx
   import qdac_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   sclk_s,
   input  logic   csn_s,
   input  logic   mosi_s,
   output frame_t frame_q,
   output logic   commit,
   output logic   sclk_fall,
   output logic   cs_fall
);
   localparam int CNT_MAX = FRAME_W + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   logic               sclk_q, csn_q;
   logic               sclk_rise, cs_rise;
   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   count;

   assign sclk_rise = sclk_s & ~sclk_q;
   assign sclk_fall = ~sclk_s & sclk_q;
   assign cs_rise   = csn_s & ~csn_q;
   assign cs_fall   = ~csn_s & csn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q  <= 1'b0;
         csn_q   <= 1'b1;
         shreg   <= '0;
         count   <= '0;
         commit  <= 1'b0;
         frame_q <= '0;
      end else begin
         sclk_q <= sclk_s;
         csn_q  <= csn_s;
         commit <= cs_rise && (count == CNT_W'(FRAME_W));
         if (cs_rise && (count == CNT_W'(FRAME_W))) frame_q <= frame_t'(shreg);
         if (cs_fall) begin
            count <= '0;
         end else if (!csn_s && sclk_rise) begin
            shreg <= {shreg[FRAME_W-2:0], mosi_s};
            if (count != CNT_W'(CNT_MAX)) count <= count + 1'b1;
         end
      end
   end
endmodule

// File: rtl/qdac_chan.sv
module qdac_chan #(
   parameter int DAC_BITS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                load_stage,
   input  logic                load_live,
   input  logic                promote,
   input  logic [DAC_BITS-1:0] code,
   output logic [DAC_BITS-1:0] stage_q,
   output logic [DAC_BITS-1:0] live_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         live_q  <= '0;
      end else if (clr) begin
         stage_q <= '0;
         live_q  <= '0;
      end else begin
         if (load_stage) stage_q <= code;
         if (load_live)  live_q  <= code;
         else if (promote) live_q <= stage_q;
      end
   end
endmodule

// File: rtl/qdac_readback.sv
module qdac_readback
   import qdac_pkg::*;
#(
   parameter int DAC_BITS = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             csn_s,
   input  logic                             cs_fall,
   input  logic                             sclk_fall,
   input  logic                             arm,
   input  logic                             drop,
   input  logic [MASK_W-1:0]                mask,
   input  logic [NUM_CH-1:0][DAC_BITS-1:0]  stage_codes,
   output logic                             miso
);
   logic               pending;
   logic [MASK_W-1:0]  mask_q;
   logic [FRAME_W-1:0] sh;
   logic [DATA_W-1:0]  pick;

   always_comb begin
      pick = '0;
      for (int i = NUM_CH - 1; i >= 0; i--)
         if (mask_q[i]) pick = DATA_W'(stage_codes[i]) << (DATA_W - DAC_BITS);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         mask_q  <= '0;
         sh      <= '0;
      end else begin
         if (csn_s)          sh <= '0;
         else if (cs_fall)   sh <= pending ? FRAME_W'(pick) : '0;
         else if (sclk_fall) sh <= {sh[FRAME_W-2:0], 1'b0};

         if (drop) begin
            pending <= 1'b0;
         end else if (arm) begin
            pending <= 1'b1;
            mask_q  <= mask;
         end else if (cs_fall) begin
            pending <= 1'b0;
         end
      end
   end

   assign miso = sh[FRAME_W-1];
endmodule

// File: rtl/qdac_cmd_decoder.sv
module qdac_cmd_decoder
   import qdac_pkg::*;
#(
   parameter int DAC_BITS    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       spi_sclk,
   input  logic                       spi_cs_n,
   input  logic                       spi_mosi,
   output logic                       spi_miso,
   output logic [NUM_CH*DAC_BITS-1:0] dac_codes,
   output logic [2*NUM_CH-1:0]        pd_modes,
   output logic                       int_ref_en
);
   generate
      if (!(DAC_BITS == 12 || DAC_BITS == 14 || DAC_BITS == 16)) begin : g_bad_res
         $error("qdac_cmd_decoder: DAC_BITS must be 12, 14 or 16");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("qdac_cmd_decoder: SYNC_STAGES must be 0 to 4");
      end
      if (NUM_CH > MASK_W) begin : g_bad_ch
         $error("qdac_cmd_decoder: channel count exceeds mask width");
      end
   endgenerate

   logic [2:0] pins_s;
   logic       sclk_s, csn_s, mosi_s;
   frame_t     frame_q;
   logic       commit, sclk_fall, cs_fall;

   logic [NUM_CH-1:0][DAC_BITS-1:0] stage_codes, live_codes;
   logic [DAC_BITS-1:0]             code;
   logic                            is_stage, is_live, is_promote, is_clear;

   qdac_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_sclk, spi_cs_n, spi_mosi}),
      .q     (pins_s)
   );
   assign sclk_s = pins_s[2];
   assign csn_s  = pins_s[1];
   assign mosi_s = pins_s[0];

   qdac_frame_rx u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (sclk_s),
      .csn_s     (csn_s),
      .mosi_s    (mosi_s),
      .frame_q   (frame_q),
      .commit    (commit),
      .sclk_fall (sclk_fall),
      .cs_fall   (cs_fall)
   );

   assign code       = frame_q.data[DATA_W-1 -: DAC_BITS];
   assign is_stage   = commit && (frame_q.op == OP_STAGE || frame_q.op == OP_DIRECT);
   assign is_live    = commit && (frame_q.op == OP_DIRECT);
   assign is_promote = commit && (frame_q.op == OP_PROMOTE);
   assign is_clear   = commit && (frame_q.op == OP_CLEAR);

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         qdac_chan #(.DAC_BITS(DAC_BITS)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (is_clear),
            .load_stage (is_stage && frame_q.mask[ch]),
            .load_live  (is_live && frame_q.mask[ch]),
            .promote    (is_promote && frame_q.mask[ch]),
            .code       (code),
            .stage_q    (stage_codes[ch]),
            .live_q     (live_codes[ch])
         );
         assign dac_codes[ch*DAC_BITS +: DAC_BITS] = live_codes[ch];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_modes   <= '0;
         int_ref_en <= 1'b1;
      end else if (commit) begin
         if (frame_q.op == OP_CLEAR)  pd_modes   <= '0;
         if (frame_q.op == OP_POWER)  pd_modes   <= frame_q.data[2*NUM_CH-1:0];
         if (frame_q.op == OP_REFSEL) int_ref_en <= ~frame_q.data[0];
      end
   end

   qdac_readback #(.DAC_BITS(DAC_BITS)) u_rb (
      .clk         (clk),
      .rst_n       (rst_n),
      .csn_s       (csn_s),
      .cs_fall     (cs_fall),
      .sclk_fall   (sclk_fall),
      .arm         (commit && frame_q.op == OP_PEEK),
      .drop        (is_clear),
      .mask        (frame_q.mask),
      .stage_codes (stage_codes),
      .miso        (spi_miso)
   );
endmodule

// File: rtl/qdac_cmd_decoder_chk.sv
module qdac_cmd_decoder_chk
   import qdac_pkg::*;
#(
   parameter int DAC_BITS = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       commit,
   input frame_t                     frame_q,
   input logic                       csn_s,
   input logic                       spi_miso,
   input logic [NUM_CH*DAC_BITS-1:0] dac_codes,
   input logic [2*NUM_CH-1:0]        pd_modes,
   input logic                       int_ref_en
);
   logic inert_op;
   assign inert_op = (frame_q.op == OP_NOP) || (frame_q.op == OP_GATE) ||
                     (frame_q.op == OP_CHAIN) || (frame_q.op > OP_PEEK);

   assert_hold_between_frames_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(dac_codes) && $stable(pd_modes) && $stable(int_ref_en));

   assert_inert_ops_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && inert_op) |=> $stable(dac_codes) && $stable(pd_modes) && $stable(int_ref_en));

   assert_power_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && frame_q.op == OP_POWER) |=> pd_modes == $past(frame_q.data[2*NUM_CH-1:0]));

   assert_ref_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && frame_q.op == OP_REFSEL) |=> int_ref_en == !$past(frame_q.data[0]));

   assert_clear_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && frame_q.op == OP_CLEAR) |=> dac_codes == '0 && pd_modes == '0 && $stable(int_ref_en));

   assert_miso_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (csn_s && $past(csn_s)) |-> !spi_miso);
endmodule

bind qdac_cmd_decoder qdac_cmd_decoder_chk #(.DAC_BITS(DAC_BITS)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .commit     (commit),
   .frame_q    (frame_q),
   .csn_s      (csn_s),
   .spi_miso   (spi_miso),
   .dac_codes  (dac_codes),
   .pd_modes   (pd_modes),
   .int_ref_en (int_ref_en)
);

// File: tb/qdac_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module qdac_cmd_decoder_tb_top;
   localparam int RES  = 12;
   localparam int SYNC = 2;
   localparam int LAT  = SYNC + 2;
   localparam int H    = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n, sclk, cs_n, mosi, miso, ref_en;
   logic [47:0] codes;
   logic [7:0]  pd;
   int          cyc = 0;
   int          n_checks = 0;
   int          n_errors = 0;

   always @(posedge clk) cyc++;

   qdac_cmd_decoder #(.DAC_BITS(RES), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_miso(miso), .dac_codes(codes), .pd_modes(pd), .int_ref_en(ref_en)
   );

   typedef struct {
      int          kind;
      int          req;
      int          due;
      logic [56:0] pre_s, post_s;
      logic [23:0] got_rb, exp_rb;
   } item_t;
   item_t sb[$];

   logic [11:0] m_stage [4];
   logic [11:0] m_live  [4];
   logic [7:0]  m_pd;
   logic        m_ref, m_pend;
   logic [3:0]  m_mask;

   function automatic logic [56:0] snap();
      logic [47:0] c;
      for (int i = 0; i < 4; i++) c[i*12 +: 12] = m_live[i];
      return {c, m_pd, m_ref};
   endfunction

   task automatic check(input int req, input logic [63:0] got, input logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL R%0d got %h expected %h at cycle %0d", req, got, exp, cyc);
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic [3:0] mask, input logic [15:0] data);
      case (op)
         4'h1: for (int i = 0; i < 4; i++) if (mask[i]) m_stage[i] = data[15:4];
         4'h2: for (int i = 0; i < 4; i++) if (mask[i]) m_live[i] = m_stage[i];
         4'h3: for (int i = 0; i < 4; i++) if (mask[i]) begin
                  m_stage[i] = data[15:4];
                  m_live[i]  = data[15:4];
               end
         4'h4: m_pd = data[7:0];
         4'h6: begin
                  for (int i = 0; i < 4; i++) begin m_stage[i] = '0; m_live[i] = '0; end
                  m_pd = '0;
                  m_pend = 1'b0;
               end
         4'h7: m_ref = ~data[0];
         4'h9: begin m_pend = 1'b1; m_mask = mask; end
         default: ;
      endcase
   endtask

   // driver: sends one frame, predicts its effects and pushes them into the scoreboard
   task automatic frame(input logic [3:0] op, input logic [3:0] mask, input logic [15:0] data,
                        input int nbits, input int req);
      logic [23:0] w, rx, exp_rb;
      item_t it;
      w = {op, mask, data};
      exp_rb = '0;
      if (m_pend)
         for (int i = 3; i >= 0; i--) if (m_mask[i]) exp_rb = {8'h00, m_stage[i], 4'h0};
      m_pend = 1'b0;
      rx = '0;
      @(negedge clk) cs_n = 1'b0;
      for (int b = 0; b < nbits; b++) begin
         mosi = (b < 24) ? w[23-b] : 1'b0;
         repeat (H) @(negedge clk);
         rx = {rx[22:0], miso};
         sclk = 1'b1;
         repeat (H) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (H) @(negedge clk);
      if (nbits == 24) begin
         it.kind = 1; it.req = 8; it.due = 0;
         it.got_rb = rx; it.exp_rb = exp_rb;
         it.pre_s = '0; it.post_s = '0;
         sb.push_back(it);
      end
      it.kind = 0;
      it.req = req;
      it.pre_s = snap();
      if (nbits == 24) apply(op, mask, data);
      it.post_s = snap();
      it.got_rb = '0; it.exp_rb = '0;
      cs_n = 1'b1;
      it.due = cyc + LAT;
      sb.push_back(it);
      repeat (H) @(negedge clk);
   endtask

   // monitor: pops expected items and compares them on their due cycle
   initial begin
      item_t it;
      forever begin
         wait (sb.size() != 0);
         it = sb.pop_front();
         if (it.kind == 1) begin
            check(it.req, 64'(it.got_rb), 64'(it.exp_rb));  // R8 readback word
         end else begin
            while (cyc < it.due - 1) @(negedge clk);
            check(12, 64'({codes, pd, ref_en}), 64'(it.pre_s));   // R12 not before due
            @(negedge clk);
            check(it.req, 64'({codes, pd, ref_en}), 64'(it.post_s));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) begin m_stage[i] = '0; m_live[i] = '0; end
      m_pd = '0; m_ref = 1'b1; m_pend = 1'b0; m_mask = '0;
      rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R2 reset state
      check(2, 64'({codes, pd, ref_en, miso}), 64'({48'h0, 8'h00, 1'b1, 1'b0}));

      frame(4'h1, 4'b0001, 16'hABC5, 24, 3);    // R3 stage only, live unchanged
      frame(4'h9, 4'b0001, 16'h0000, 24, 8);    // R8 arm readback of channel 0
      frame(4'h0, 4'b0000, 16'h0000, 24, 11);   // R11 readback 00ABC0, low nibble dropped
      frame(4'h2, 4'b0001, 16'h0000, 24, 4);    // R4 promote channel 0
      frame(4'h3, 4'b1111, 16'h1234, 24, 5);    // R5 all channels direct
      frame(4'h3, 4'b0100, 16'hFFFF, 24, 11);   // R11 channel 2 full scale
      frame(4'h1, 4'b0010, 16'h5550, 24, 3);    // R3 stage channel 1
      frame(4'h2, 4'b1111, 16'h0000, 24, 4);    // R4 promote all
      frame(4'h4, 4'b0000, 16'h00E4, 24, 6);    // R6 one power code per channel
      frame(4'h7, 4'b0000, 16'h0001, 24, 7);    // R7 reference off
      frame(4'h7, 4'b0000, 16'hFFFE, 24, 7);    // R7 reference on
      frame(4'h7, 4'b0000, 16'h0001, 24, 7);    // R7 reference off again
      frame(4'h5, 4'b1111, 16'hFFFF, 24, 10);   // R10 inert operations
      frame(4'h8, 4'b1111, 16'hFFFF, 24, 10);
      frame(4'hA, 4'b1111, 16'hFFFF, 24, 10);
      frame(4'hF, 4'b1111, 16'hFFFF, 24, 10);
      frame(4'h0, 4'b1111, 16'hFFFF, 24, 10);
      frame(4'h3, 4'b1111, 16'h0000, 23, 1);    // R1 short frame discarded
      frame(4'h3, 4'b1111, 16'h0000, 25, 1);    // R1 long frame discarded
      frame(4'h9, 4'b0110, 16'h0000, 24, 8);    // R8 lowest selected is channel 1
      frame(4'h0, 4'b0000, 16'h0000, 24, 8);
      frame(4'h9, 4'b0000, 16'h0000, 24, 8);    // R8 empty mask reads zero
      frame(4'h0, 4'b0000, 16'h0000, 24, 8);
      frame(4'h0, 4'b0000, 16'h0000, 24, 8);    // R8 no request, MISO quiet
      frame(4'h9, 4'b0001, 16'h0000, 24, 8);
      frame(4'h6, 4'b0000, 16'h0000, 24, 9);    // R9 clear, reference kept
      frame(4'h0, 4'b0000, 16'h0000, 24, 9);    // R9 readback dropped

      repeat (LAT + 10) @(negedge clk);
      wait (sb.size() == 0);
      repeat (LAT + 4) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule